// File: doc/BRIEF.md
# Receive Queue Resolver

For every packet, this block picks the receive queue that the packet lands in. The block receives a strobe with three inputs: the ingress port, the packet's classifier attribute words and a flow hash. It first builds an 8-bit queue number from two parts. The 3-bit low part always comes from the classifier. The 5-bit high part comes either from the classifier or from an override register for the ingress port. If the classifier has set the RSS flag, the block sends that queue number through a queue-to-table map. The map selects one of several 32-entry indirection tables, and the hash then selects the entry that holds the final queue. When a queue has no valid map entry, the packet is dropped.

Software configures the block through a small write/read register port. A selector register holds three index fields: a table entry, a table number and a map slot. Two data registers then access the table entry or the map slot that the selector points at. The port mask and the per-port override registers are written directly. The output stage is a three-state machine that holds the result for the cycle after the strobe:
- IDLE: no result.
- QUEUE: a queue is delivered.
- DROP: the packet is discarded.

Each cycle, the next state is chosen from the strobe and the lookup outcome:
- A strobe that resolves to a queue takes the machine to QUEUE.
- A strobe that reaches an unmapped queue takes the machine to DROP.
- No strobe takes the machine to IDLE.

Any of these transitions can leave any state.

Top module: `rxq_resolver`

## Requirements
- R1: After reset, `res_valid` and `res_drop` are low, the port mask (address 3) and all override registers read 0, and every map slot reads invalid (bit 8 of address 2 is 0). As a result, any RSS lookup is dropped until software programs the map.
- R2: A strobe on `in_valid` gives exactly one `res_valid` pulse, one clock cycle later. Back-to-back strobes give back-to-back results in the same order.
- R3: The queue is {qhigh, qlow}. qlow is `in_attr0[23:21]`. When the port's mask bit is clear, qhigh is `in_attr0[28:24]`. Bit 29 of the attribute word has no effect.
- R4: When bit p of the port mask (address 3) is set, qhigh for packets from port p is the override register at address 4+p, bits 4:0. The classifier's qhigh is then ignored. Ports whose mask bit is clear are not affected.
- R5: When `in_attr2[30]` is 0, the composed queue is the result and `res_drop` stays low.
- R6: When `in_attr2[30]` is 1 and the map slot of the composed queue is valid, the result is entry `in_hash[4:0]` of the table that the slot points to.
- R7: When `in_attr2[30]` is 1 and the map slot is invalid, `res_valid` and `res_drop` are high together and `res_queue` is 0.
- R8: The selector register (address 0) holds the table entry in bits 7:0, the table number in bits 15:8 and the map slot in bits 23:16. Address 1 writes and reads the selected table entry (8-bit queue). Address 2 writes and reads the selected map slot: bit 8 is the valid bit and the low bits hold the table pointer.
- R9: A register write takes effect on the cycle after it. A packet strobed in the same cycle as a write still sees the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet strobe |
| in_port | input | $clog2(NUM_PORTS) | Ingress port number |
| in_attr0 | input | 32 | Classifier attribute word carrying the queue parts |
| in_attr2 | input | 32 | Classifier attribute word carrying the RSS flag |
| in_hash | input | $clog2(TBL_ENTRIES) | Flow hash bits that select the table entry |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| res_valid | output | 1 | Result present |
| res_queue | output | 8 | Resolved queue number |
| res_drop | output | 1 | Packet dropped: no map entry for its queue |

## Verification
The bench builds the block with its default parameters: 4 ports, 8 tables and 32 entries per table. With these values, all 256 map slots and every table index that the selector bits can encode are in play. They also let port 1 use the override value 4 (its first queue 32 shifted right by 3), which moves that port's traffic into queues 32 to 39. With this override in place, the bench compares the classifier-driven case and the override-driven case for the same attribute word. It also hits an unmapped slot both before and after mapping it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int QW      = 8;
    localparam int QLOW_W  = 3;
    localparam int QHIGH_W = 5;

    localparam int QLOW_LSB  = 21;
    localparam int QHIGH_LSB = 24;
    localparam int RSS_BIT   = 30;

    localparam logic [3:0] REG_SEL  = 4'd0;
    localparam logic [3:0] REG_TBL  = 4'd1;
    localparam logic [3:0] REG_MAP  = 4'd2;
    localparam logic [3:0] REG_MASK = 4'd3;
    localparam int         REG_OVR0 = 4;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_QUEUE = 2'd1,
        OUT_DROP  = 2'd2
    } out_state_e;
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
    import rxq_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_TABLES  = 8,
    parameter int TBL_ENTRIES = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_wr,
    input  logic [3:0]                           cfg_addr,
    input  logic [31:0]                          cfg_wdata,
    output logic [31:0]                          cfg_rdata,
    output logic [NUM_PORTS-1:0]                 port_mask,
    output logic [NUM_PORTS-1:0][QHIGH_W-1:0]    port_ovr,
    input  logic [QW-1:0]                        map_q,
    output logic                                 map_hit,
    output logic [$clog2(NUM_TABLES)-1:0]        map_ptr,
    input  logic [$clog2(NUM_TABLES)-1:0]        rss_ptr,
    input  logic [$clog2(TBL_ENTRIES)-1:0]       rss_idx,
    output logic [QW-1:0]                        rss_queue
);
    localparam int TW  = $clog2(NUM_TABLES);
    localparam int EW  = $clog2(TBL_ENTRIES);
    localparam int QN  = 1 << QW;
    localparam int TN  = NUM_TABLES * TBL_ENTRIES;

    logic [EW-1:0]  e_sel;
    logic [TW-1:0]  t_sel;
    logic [QW-1:0]  q_sel;
    logic [QN-1:0]  map_v;
    logic [TW-1:0]  map_p [QN];
    logic [QW-1:0]  tbl   [TN];

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_sel     <= '0;
            t_sel     <= '0;
            q_sel     <= '0;
            port_mask <= '0;
            map_v     <= '0;
            for (int i = 0; i < QN; i++) map_p[i] <= '0;
            for (int i = 0; i < TN; i++) tbl[i] <= '0;
        end else if (cfg_wr) begin
            unique case (cfg_addr)
                REG_SEL: begin
                    e_sel <= cfg_wdata[EW-1:0];
                    t_sel <= cfg_wdata[8 +: TW];
                    q_sel <= cfg_wdata[16 +: QW];
                end
                REG_TBL:  tbl[{t_sel, e_sel}] <= cfg_wdata[QW-1:0];
                REG_MAP: begin
                    map_v[q_sel] <= cfg_wdata[8];
                    map_p[q_sel] <= cfg_wdata[TW-1:0];
                end
                REG_MASK: port_mask <= cfg_wdata[NUM_PORTS-1:0];
                default: ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ovr
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_ovr[p] <= '0;
            else if (cfg_wr && cfg_addr == 4'(REG_OVR0 + p))
                port_ovr[p] <= cfg_wdata[QHIGH_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            REG_SEL: begin
                cfg_rdata[EW-1:0]    = e_sel;
                cfg_rdata[8 +: TW]   = t_sel;
                cfg_rdata[16 +: QW]  = q_sel;
            end
            REG_TBL:  cfg_rdata[QW-1:0] = tbl[{t_sel, e_sel}];
            REG_MAP: begin
                cfg_rdata[8]      = map_v[q_sel];
                cfg_rdata[TW-1:0] = map_p[q_sel];
            end
            REG_MASK: cfg_rdata[NUM_PORTS-1:0] = port_mask;
            default: begin
                for (int p = 0; p < NUM_PORTS; p++)
                    if (cfg_addr == 4'(REG_OVR0 + p))
                        cfg_rdata[QHIGH_W-1:0] = port_ovr[p];
            end
        endcase
    end

    assign map_hit   = map_v[map_q];
    assign map_ptr   = map_p[map_q];
    assign rss_queue = tbl[{rss_ptr, rss_idx}];
endmodule

// File: rtl/rxq_select.sv
module rxq_select
    import rxq_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [$clog2(NUM_PORTS)-1:0]      in_port,
    input  logic [31:0]                       in_attr0,
    input  logic [NUM_PORTS-1:0]              port_mask,
    input  logic [NUM_PORTS-1:0][QHIGH_W-1:0] port_ovr,
    output logic [QW-1:0]                     comp_queue
);
    logic [QHIGH_W-1:0] qhigh;
    logic [QLOW_W-1:0]  qlow;

    assign qlow  = in_attr0[QLOW_LSB +: QLOW_W];
    assign qhigh = port_mask[in_port] ? port_ovr[in_port]
                                      : in_attr0[QHIGH_LSB +: QHIGH_W];
    assign comp_queue = {qhigh, qlow};
endmodule

// File: rtl/rxq_resolver.sv
module rxq_resolver
    import rxq_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_TABLES  = 8,
    parameter int TBL_ENTRIES = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [$clog2(NUM_PORTS)-1:0]     in_port,
    input  logic [31:0]                      in_attr0,
    input  logic [31:0]                      in_attr2,
    input  logic [$clog2(TBL_ENTRIES)-1:0]   in_hash,
    input  logic                             cfg_wr,
    input  logic [3:0]                       cfg_addr,
    input  logic [31:0]                      cfg_wdata,
    output logic [31:0]                      cfg_rdata,
    output logic                             res_valid,
    output logic [7:0]                       res_queue,
    output logic                             res_drop
);
    localparam int TW = $clog2(NUM_TABLES);

    logic [NUM_PORTS-1:0]              port_mask;
    logic [NUM_PORTS-1:0][QHIGH_W-1:0] port_ovr;
    logic [QW-1:0]                     comp_queue;
    logic                              map_hit;
    logic [TW-1:0]                     map_ptr;
    logic [QW-1:0]                     rss_queue;
    logic                              rss_on;
    logic                              drop_now;
    logic [QW-1:0]                     pick_queue;
    out_state_e                        state_q, state_d;
    logic [QW-1:0]                     queue_q;

    logic unused_attr;
    assign unused_attr = ^{in_attr0, in_attr2};

    rxq_cfg #(
        .NUM_PORTS  (NUM_PORTS),
        .NUM_TABLES (NUM_TABLES),
        .TBL_ENTRIES(TBL_ENTRIES)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .port_mask (port_mask),
        .port_ovr  (port_ovr),
        .map_q     (comp_queue),
        .map_hit   (map_hit),
        .map_ptr   (map_ptr),
        .rss_ptr   (map_ptr),
        .rss_idx   (in_hash),
        .rss_queue (rss_queue)
    );

    rxq_select #(.NUM_PORTS(NUM_PORTS)) u_sel (
        .in_port    (in_port),
        .in_attr0   (in_attr0),
        .port_mask  (port_mask),
        .port_ovr   (port_ovr),
        .comp_queue (comp_queue)
    );

    assign rss_on     = in_attr2[RSS_BIT];
    assign drop_now   = rss_on && !map_hit;
    assign pick_queue = rss_on ? rss_queue : comp_queue;

    always_comb begin
        state_d = OUT_IDLE;
        if (in_valid)
            state_d = drop_now ? OUT_DROP : OUT_QUEUE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            queue_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && !drop_now)
                queue_q <= pick_queue;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        res_drop  = 1'b0;
        res_queue = '0;
        unique case (state_q)
            OUT_IDLE: ;
            OUT_QUEUE: begin
                res_valid = 1'b1;
                res_queue = queue_q;
            end
            OUT_DROP: begin
                res_valid = 1'b1;
                res_drop  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxq_resolver_chk.sv
module rxq_resolver_chk #(
    parameter int NUM_PORTS   = 4,
    parameter int TBL_ENTRIES = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic [31:0]                    in_attr0,
    input logic [31:0]                    in_attr2,
    input logic                           res_valid,
    input logic [7:0]                     res_queue,
    input logic                           res_drop
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    assert_drop_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (res_valid && res_queue == 8'd0));

    assert_plain_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_attr2[30]) |=> !res_drop);

    assert_qlow_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_attr2[30]) |=> res_queue[2:0] == $past(in_attr0[23:21]));
endmodule

bind rxq_resolver rxq_resolver_chk #(
    .NUM_PORTS  (NUM_PORTS),
    .TBL_ENTRIES(TBL_ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_attr0  (in_attr0),
    .in_attr2  (in_attr2),
    .res_valid (res_valid),
    .res_queue (res_queue),
    .res_drop  (res_drop)
);

// File: tb/test_rxq_resolver.sv
`timescale 1ns/1ps
module test_rxq_resolver;
    localparam int NP = 4;
    localparam int NT = 8;
    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_port = '0;
    logic [31:0] in_attr0 = '0;
    logic [31:0] in_attr2 = '0;
    logic [4:0]  in_hash = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        res_valid;
    logic [7:0]  res_queue;
    logic        res_drop;

    always #5 clk = ~clk;

    rxq_resolver #(.NUM_PORTS(NP), .NUM_TABLES(NT), .TBL_ENTRIES(NE)) i_rxq_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .in_attr0(in_attr0), .in_attr2(in_attr2), .in_hash(in_hash),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .res_valid(res_valid), .res_queue(res_queue),
        .res_drop(res_drop)
    );

    int tests = 0;
    int fails = 0;

    typedef struct { logic drop; logic [7:0] q; string tag; } exp_t;
    exp_t sb[$];

    logic [255:0] m_mv = '0;
    logic [2:0]   m_mp [256];
    logic [7:0]   m_tb [NT][NE];
    logic [3:0]   m_mask = '0;
    logic [4:0]   m_ovr [NP];
    logic [4:0]   m_e = '0;
    logic [2:0]   m_t = '0;
    logic [7:0]   m_q = '0;

    initial begin
        for (int i = 0; i < 256; i++) m_mp[i] = '0;
        for (int t = 0; t < NT; t++) for (int e = 0; e < NE; e++) m_tb[t][e] = '0;
        for (int p = 0; p < NP; p++) m_ovr[p] = '0;
    end

    function automatic exp_t model(input logic [1:0] port, input logic [31:0] a0,
                                   input logic [31:0] a2, input logic [4:0] h, input string tag);
        exp_t r;
        logic [4:0] qh;
        logic [7:0] q;
        qh = m_mask[port] ? m_ovr[port] : a0[28:24];
        q  = {qh, a0[23:21]};
        r.tag = tag;
        r.drop = 1'b0;
        r.q = q;
        if (a2[30]) begin
            if (!m_mv[q]) begin r.drop = 1'b1; r.q = 8'd0; end
            else r.q = m_tb[m_mp[q]][h];
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_a0(input logic [5:0] qh, input logic [2:0] ql);
        return {2'b00, qh, ql, 21'd0};
    endfunction

    task automatic shadow_write(input logic [3:0] a, input logic [31:0] d);
        case (a)
            4'd0: begin m_e = d[4:0]; m_t = d[10:8]; m_q = d[23:16]; end
            4'd1: m_tb[m_t][m_e] = d[7:0];
            4'd2: begin m_mv[m_q] = d[8]; m_mp[m_q] = d[2:0]; end
            4'd3: m_mask = d[3:0];
            default: if (a >= 4 && a < 4 + NP) m_ovr[a - 4] = d[4:0];
        endcase
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        shadow_write(a, d);
    endtask

    task automatic cfg_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b0; cfg_wr = 1'b0; cfg_addr = a;
        #1;
        tests++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: reg %0d read %h expected %h", tag, a, cfg_rdata, exp);
        end
    endtask

    task automatic send_pkt(input logic [1:0] port, input logic [31:0] a0,
                            input logic [31:0] a2, input logic [4:0] h, input string tag);
        @(negedge clk);
        cfg_wr = 1'b0;
        in_valid = 1'b1; in_port = port; in_attr0 = a0; in_attr2 = a2; in_hash = h;
        sb.push_back(model(port, a0, a2, h, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compares each result against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected result q=%0d drop=%0b expected none", res_queue, res_drop);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_drop !== e.drop || res_queue !== e.q) begin
                    fails++;
                    $display("FAIL %s: got q=%0d drop=%0b expected q=%0d drop=%0b",
                             e.tag, res_queue, res_drop, e.q, e.drop);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [31:0] RSS = 32'h4000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        tests++;
        if (res_valid !== 1'b0 || res_drop !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b drop=%0b expected 0 0", res_valid, res_drop);
        end
        cfg_check(4'd3, 32'h0, "R1");
        cfg_check(4'd5, 32'h0, "R1");
        cfg_check(4'd2, 32'h0, "R1");
        // R1 and R7: unmapped after reset
        send_pkt(2'd0, mk_a0(6'd0, 3'd0), RSS, 5'd3, "R7");
        idle(2);

        // R3 / R5: classifier-driven queues, bit 29 ignored
        send_pkt(2'd0, mk_a0(6'd2, 3'd5), 32'h0, 5'd0, "R3");
        send_pkt(2'd1, mk_a0(6'h3f, 3'd7), 32'h0, 5'd9, "R3");
        send_pkt(2'd2, mk_a0(6'h11, 3'd0), 32'hbfff_ffff, 5'd1, "R5");
        send_pkt(2'd3, mk_a0(6'd0, 3'd1), 32'h0, 5'd0, "R5");
        idle(2);

        // R8: selector fields and data registers
        cfg_write(4'd0, 32'h0023_0205);
        cfg_check(4'd0, 32'h0023_0205, "R8");
        cfg_write(4'd1, 32'h0000_0047);
        cfg_check(4'd1, 32'h0000_0047, "R8");
        cfg_write(4'd2, 32'h0000_0102);
        cfg_check(4'd2, 32'h0000_0102, "R8");

        // fill tables 1 and 2
        for (int t = 1; t <= 2; t++)
            for (int e = 0; e < NE; e++) begin
                cfg_write(4'd0, (t << 8) | e);
                cfg_write(4'd1, 32'((t * 32) + (e % 4)));
            end
        cfg_write(4'd0, 32'h0020_0000);
        cfg_write(4'd2, 32'h0000_0101);
        cfg_check(4'd2, 32'h0000_0101, "R8");

        // R6: hash selects the entry of the mapped table
        send_pkt(2'd0, mk_a0(6'd4, 3'd0), RSS, 5'd0, "R6");
        send_pkt(2'd0, mk_a0(6'd4, 3'd0), RSS, 5'd6, "R6");
        send_pkt(2'd2, mk_a0(6'd4, 3'd3), RSS, 5'd31, "R6");
        send_pkt(2'd2, mk_a0(6'd4, 3'd3), RSS, 5'd17, "R6");
        idle(2);

        // R4: override on port 1
        cfg_write(4'd5, 32'd4);
        cfg_check(4'd5, 32'd4, "R4");
        cfg_write(4'd3, 32'h2);
        send_pkt(2'd1, mk_a0(6'd0, 3'd1), 32'h0, 5'd0, "R4");
        send_pkt(2'd1, mk_a0(6'd9, 3'd6), 32'h0, 5'd0, "R4");
        send_pkt(2'd0, mk_a0(6'd0, 3'd1), 32'h0, 5'd0, "R4");
        // R7: overridden queue 33 unmapped
        send_pkt(2'd1, mk_a0(6'd0, 3'd1), RSS, 5'd2, "R7");
        idle(2);
        cfg_write(4'd0, 32'h0021_0000);
        cfg_write(4'd2, 32'h0000_0102);
        send_pkt(2'd1, mk_a0(6'd0, 3'd1), RSS, 5'd2, "R6");
        idle(2);

        // R9: write and packet in the same cycle
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'd3; cfg_wdata = 32'h0;
        in_valid = 1'b1; in_port = 2'd1; in_attr0 = mk_a0(6'd0, 3'd2); in_attr2 = 32'h0; in_hash = '0;
        sb.push_back(model(2'd1, in_attr0, in_attr2, in_hash, "R9"));
        shadow_write(4'd3, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b0;
        sb.push_back(model(2'd1, in_attr0, in_attr2, in_hash, "R9"));
        idle(3);

        // R2: a longer back-to-back burst
        for (int k = 0; k < 6; k++)
            send_pkt(2'(k), mk_a0(6'(k + 1), 3'(k)), (k % 2 == 0) ? 32'h0 : RSS, 5'(k * 5), "R2");
        idle(4);

        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule